// File: doc/BRIEF.md
# Debug Halt Trigger Unit

This unit decides when the processor has to stop and hand control to an external debugger. It watches two sources. The first is a one-cycle pulse from the instruction decoder, raised when it decodes the software break opcode (00H). The second is the stream of register-file accesses: a 12-bit address, an 8-bit data byte, and separate read and write strobes.

A small configuration store holds the trigger settings and is loaded in one cycle from a debugger-side write strobe. The settings are:

- a break-instruction enable;
- a single watched address;
- read-trigger and write-trigger enables;
- an optional data-compare enable with its compare byte.

When a trigger fires, the unit sets a halted flag and raises an idle request towards the processor. It also records whether the halt came from the break instruction or from the watchpoint. Both the flag and the idle request stay set until the debugger pulses the resume input.

Top module: `dbgw_unit`

## Requirements
- R1: After reset the halted flag, the idle request and the source code are all 0, and every trigger enable is cleared.
- R2: With the break-instruction enable set, a break pulse sets the halted flag and the idle request from the next cycle, and the source code becomes 2'b01.
- R3: With the break-instruction enable clear, a break pulse leaves the halted flag, the idle request and the source code unchanged, so the instruction behaves as a no-op.
- R4: The watchpoint compares all 12 address bits against one configured address. An access to any other address never triggers.
- R5: The read enable arms the watchpoint for accesses with the read strobe, and the write enable arms it for accesses with the write strobe. Either enable may be set alone, or both together.
- R6: With the data-compare enable set, an address hit triggers only when the accessed byte equals the compare byte. With it clear, the data is not looked at.
- R7: A watchpoint hit halts exactly like an enabled break instruction, one cycle later, and sets the source code to 2'b10.
- R8: If a break pulse and a watchpoint hit arrive in the same cycle, the source code is 2'b01.
- R9: The halted flag and the idle request hold until resume is pulsed while halted. They clear on the next cycle, and the source code keeps the value of the last halt.
- R10: A break pulse or watchpoint hit that arrives while halted has no effect, and the source code stays unchanged.
- R11: A configuration load takes effect from the following cycle. An access in the same cycle as the load is compared against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_op_i | input | 1 | Decoder pulse: break opcode seen |
| rf_addr_i | input | 12 | Register-file access address |
| rf_data_i | input | 8 | Byte read or written |
| rf_rd_i | input | 1 | Read strobe |
| rf_wr_i | input | 1 | Write strobe |
| cfg_load_i | input | 1 | Load all configuration fields |
| cfg_bp_en_i | input | 1 | Break-instruction enable |
| cfg_wp_addr_i | input | 12 | Watched address |
| cfg_wp_rd_en_i | input | 1 | Trigger on reads |
| cfg_wp_wr_en_i | input | 1 | Trigger on writes |
| cfg_wp_dat_en_i | input | 1 | Require data equality |
| cfg_wp_dat_i | input | 8 | Compare byte |
| resume_i | input | 1 | Debugger resume command |
| dbg_mode_o | output | 1 | Halted flag |
| cpu_idle_o | output | 1 | Idle request to the processor |
| brk_src_o | output | 2 | Last halt source: 01 break instruction, 10 watchpoint |

## Verification
The bench probes an address that differs from the watched one only in its top bit. A design that compares a truncated address would halt there. It also sends accesses with the wrong strobe direction, and bytes that are one off the compare value. These catch strobe enables that are swapped or ORed together, and a data compare that is ignored.

A break and a watchpoint hit are driven in the same cycle to pin down the source priority. Triggers are also driven while the unit is already halted; a design that relatches would corrupt the source code. Finally, a configuration load coincides with an access, which exposes a compare that uses the new settings too early.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_SWBRK = 2'b01,
        SRC_WATCH = 2'b10
    } brk_src_e;

endpackage

// File: rtl/dbgw_cfg_regs.sv
module dbgw_cfg_regs #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          bp_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic          dat_en_i,
    input  logic [DW-1:0] dat_i,
    output logic          bp_en_o,
    output logic [AW-1:0] addr_o,
    output logic          rd_en_o,
    output logic          wr_en_o,
    output logic          dat_en_o,
    output logic [DW-1:0] dat_o
);

    typedef struct packed {
        logic          bp_en;
        logic          rd_en;
        logic          wr_en;
        logic          dat_en;
        logic [AW-1:0] addr;
        logic [DW-1:0] dat;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) begin
            cfg_d.bp_en  = bp_en_i;
            cfg_d.rd_en  = rd_en_i;
            cfg_d.wr_en  = wr_en_i;
            cfg_d.dat_en = dat_en_i;
            cfg_d.addr   = addr_i;
            cfg_d.dat    = dat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign bp_en_o  = cfg_q.bp_en;
    assign addr_o   = cfg_q.addr;
    assign rd_en_o  = cfg_q.rd_en;
    assign wr_en_o  = cfg_q.wr_en;
    assign dat_en_o = cfg_q.dat_en;
    assign dat_o    = cfg_q.dat;

    AST_CFG_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(addr_i)) && (bp_en_o == $past(bp_en_i))); // R11
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o) && $stable(dat_o)); // R11

endmodule

// File: rtl/dbgw_watch_cmp.sv
module dbgw_watch_cmp #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic [AW-1:0] acc_addr_i,
    input  logic [DW-1:0] acc_dat_i,
    input  logic          acc_rd_i,
    input  logic          acc_wr_i,
    input  logic [AW-1:0] wp_addr_i,
    input  logic          wp_rd_en_i,
    input  logic          wp_wr_en_i,
    input  logic          wp_dat_en_i,
    input  logic [DW-1:0] wp_dat_i,
    output logic          hit_o
);

    logic kind_ok, addr_ok, dat_ok;

    always_comb begin
        kind_ok = (acc_rd_i & wp_rd_en_i) | (acc_wr_i & wp_wr_en_i);
        addr_ok = (acc_addr_i == wp_addr_i);
        dat_ok  = !wp_dat_en_i || (acc_dat_i == wp_dat_i);
        hit_o   = kind_ok && addr_ok && dat_ok;
    end

endmodule

// File: rtl/dbgw_ctrl.sv
module dbgw_ctrl
    import dbgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       brk_op_i,
    input  logic       bp_en_i,
    input  logic       wp_hit_i,
    input  logic       resume_i,
    output logic       dbg_o,
    output logic [1:0] src_o
);

    typedef struct packed {
        logic     dbg;
        brk_src_e src;
    } st_t;

    st_t st_d, st_q;
    logic bp_hit;

    always_comb begin
        bp_hit = brk_op_i && bp_en_i;
        st_d   = st_q;
        if (st_q.dbg) begin
            if (resume_i) st_d.dbg = 1'b0;
        end else if (bp_hit) begin
            st_d.dbg = 1'b1;
            st_d.src = SRC_SWBRK;
        end else if (wp_hit_i) begin
            st_d.dbg = 1'b1;
            st_d.src = SRC_WATCH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{dbg: 1'b0, src: SRC_NONE};
        else        st_q <= st_d;
    end

    assign dbg_o = st_q.dbg;
    assign src_o = st_q.src;

    AST_BRK_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_o && brk_op_i && bp_en_i) |=> dbg_o && (src_o == 2'b01)); // R2
    AST_BRK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_o && brk_op_i && !bp_en_i && !wp_hit_i) |=> !dbg_o && $stable(src_o)); // R3
    AST_WP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_o && wp_hit_i && !(brk_op_i && bp_en_i)) |=> dbg_o && (src_o == 2'b10)); // R7
    AST_HOLD_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_o && !resume_i) |=> dbg_o && $stable(src_o)); // R10
    AST_RESUME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_o && resume_i) |=> !dbg_o && $stable(src_o)); // R9
    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_o)); // R8

endmodule

// File: rtl/dbgw_unit.sv
module dbgw_unit #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          brk_op_i,
    input  logic [AW-1:0] rf_addr_i,
    input  logic [DW-1:0] rf_data_i,
    input  logic          rf_rd_i,
    input  logic          rf_wr_i,
    input  logic          cfg_load_i,
    input  logic          cfg_bp_en_i,
    input  logic [AW-1:0] cfg_wp_addr_i,
    input  logic          cfg_wp_rd_en_i,
    input  logic          cfg_wp_wr_en_i,
    input  logic          cfg_wp_dat_en_i,
    input  logic [DW-1:0] cfg_wp_dat_i,
    input  logic          resume_i,
    output logic          dbg_mode_o,
    output logic          cpu_idle_o,
    output logic [1:0]    brk_src_o
);

    logic          bp_en, rd_en, wr_en, dat_en, wp_hit, dbg;
    logic [AW-1:0] wp_addr;
    logic [DW-1:0] wp_dat;

    dbgw_cfg_regs #(.AW(AW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load_i(cfg_load_i),
        .bp_en_i(cfg_bp_en_i), .addr_i(cfg_wp_addr_i),
        .rd_en_i(cfg_wp_rd_en_i), .wr_en_i(cfg_wp_wr_en_i),
        .dat_en_i(cfg_wp_dat_en_i), .dat_i(cfg_wp_dat_i),
        .bp_en_o(bp_en), .addr_o(wp_addr), .rd_en_o(rd_en),
        .wr_en_o(wr_en), .dat_en_o(dat_en), .dat_o(wp_dat)
    );

    dbgw_watch_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .acc_addr_i(rf_addr_i), .acc_dat_i(rf_data_i),
        .acc_rd_i(rf_rd_i), .acc_wr_i(rf_wr_i),
        .wp_addr_i(wp_addr), .wp_rd_en_i(rd_en), .wp_wr_en_i(wr_en),
        .wp_dat_en_i(dat_en), .wp_dat_i(wp_dat), .hit_o(wp_hit)
    );

    dbgw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .brk_op_i(brk_op_i), .bp_en_i(bp_en),
        .wp_hit_i(wp_hit), .resume_i(resume_i), .dbg_o(dbg), .src_o(brk_src_o)
    );

    assign dbg_mode_o = dbg;
    assign cpu_idle_o = dbg;

    AST_WP_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode_o && !brk_op_i && (rf_addr_i != wp_addr)) |=> !dbg_mode_o); // R4
    AST_WP_DATA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode_o && !brk_op_i && dat_en && (rf_data_i != wp_dat)) |=> !dbg_mode_o); // R6

endmodule

// File: tb/dbgw_unit_tb.sv
module dbgw_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        brk_op = 1'b0;
    logic [11:0] rf_addr = '0;
    logic [7:0]  rf_data = '0;
    logic        rf_rd = 1'b0, rf_wr = 1'b0;
    logic        cfg_load = 1'b0, cfg_bp = 1'b0, cfg_rd = 1'b0, cfg_wr = 1'b0, cfg_den = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [7:0]  cfg_dat = '0;
    logic        resume = 1'b0;
    logic        dbg_mode, cpu_idle;
    logic [1:0]  brk_src;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit         m_dbg = 0;
    bit [1:0]   m_src = 0;
    bit         m_bp = 0, m_rd = 0, m_wr = 0, m_den = 0;
    bit [11:0]  m_addr = 0;
    bit [7:0]   m_dat = 0;

    always #10 clk = ~clk;

    dbgw_unit dut_i (
        .clk(clk), .rst_n(rst_n), .brk_op_i(brk_op), .rf_addr_i(rf_addr),
        .rf_data_i(rf_data), .rf_rd_i(rf_rd), .rf_wr_i(rf_wr),
        .cfg_load_i(cfg_load), .cfg_bp_en_i(cfg_bp), .cfg_wp_addr_i(cfg_addr),
        .cfg_wp_rd_en_i(cfg_rd), .cfg_wp_wr_en_i(cfg_wr),
        .cfg_wp_dat_en_i(cfg_den), .cfg_wp_dat_i(cfg_dat),
        .resume_i(resume), .dbg_mode_o(dbg_mode), .cpu_idle_o(cpu_idle),
        .brk_src_o(brk_src)
    );

    always @(posedge clk) begin
        bit hb, hw;
        if (!rst_n) begin
            m_dbg = 0; m_src = 0; m_bp = 0; m_rd = 0; m_wr = 0;
            m_den = 0; m_addr = 0; m_dat = 0;
        end else begin
            hb = brk_op && m_bp;
            hw = ((rf_rd && m_rd) || (rf_wr && m_wr)) && (rf_addr == m_addr)
                 && (!m_den || rf_data == m_dat);
            if (m_dbg) begin
                if (resume) m_dbg = 0;
            end else if (hb || hw) begin
                m_dbg = 1;
                m_src = hb ? 2'b01 : 2'b10;
            end
            if (cfg_load) begin
                m_bp = cfg_bp; m_rd = cfg_rd; m_wr = cfg_wr; m_den = cfg_den;
                m_addr = cfg_addr; m_dat = cfg_dat;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (dbg_mode !== m_dbg || cpu_idle !== m_dbg || brk_src !== m_src) begin
                errors++;
                $display("FAIL %s model: dbg=%b idle=%b src=%b expected dbg=%b idle=%b src=%b",
                         cur_req, dbg_mode, cpu_idle, brk_src, m_dbg, m_dbg, m_src);
            end
        end
    end

    task automatic clr_in();
        brk_op = 0; rf_rd = 0; rf_wr = 0; rf_addr = '0; rf_data = '0;
        cfg_load = 0; resume = 0;
    endtask

    task automatic step();
        @(posedge clk); #2; clr_in();
    endtask

    task automatic chk(input bit ed, input bit [1:0] es, input string req);
        @(negedge clk);
        checks++;
        if (dbg_mode !== ed || cpu_idle !== ed || brk_src !== es) begin
            errors++;
            $display("FAIL %s: dbg=%b idle=%b src=%b expected dbg=%b idle=%b src=%b",
                     req, dbg_mode, cpu_idle, brk_src, ed, ed, es);
        end
    endtask

    task automatic set_cfg(input bit bp, input bit [11:0] a, input bit rd, input bit wr,
                           input bit den, input bit [7:0] d);
        cfg_load = 1; cfg_bp = bp; cfg_addr = a; cfg_rd = rd; cfg_wr = wr;
        cfg_den = den; cfg_dat = d;
    endtask

    task automatic acc(input bit rd, input bit wr, input bit [11:0] a, input bit [7:0] d);
        rf_rd = rd; rf_wr = wr; rf_addr = a; rf_data = d;
    endtask

    task automatic do_resume();
        cur_req = "R9"; resume = 1; step(); chk(0, brk_src, "R9");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2 rst_n = 1;
        chk(0, 2'b00, "R1");

        cur_req = "R3";
        brk_op = 1; step(); chk(0, 2'b00, "R3");

        cur_req = "R2";
        set_cfg(1, 12'h123, 1, 0, 0, 8'h00); step();
        brk_op = 1; step(); chk(1, 2'b01, "R2");
        cur_req = "R9";
        step(); chk(1, 2'b01, "R9");
        cur_req = "R10";
        acc(1, 0, 12'h123, 8'h00); step(); chk(1, 2'b01, "R10");
        brk_op = 1; step(); chk(1, 2'b01, "R10");
        do_resume(); chk(0, 2'b01, "R9");

        cur_req = "R4";
        acc(1, 0, 12'h124, 8'h00); step(); chk(0, 2'b01, "R4");
        acc(1, 0, 12'h923, 8'h00); step(); chk(0, 2'b01, "R4");
        cur_req = "R7";
        acc(1, 0, 12'h123, 8'h00); step(); chk(1, 2'b10, "R7");
        do_resume();

        cur_req = "R8";
        brk_op = 1; acc(1, 0, 12'h123, 8'h00); step(); chk(1, 2'b01, "R8");
        do_resume();

        cur_req = "R5";
        set_cfg(0, 12'h123, 1, 0, 0, 8'h00); step();
        acc(0, 1, 12'h123, 8'h00); step(); chk(0, 2'b01, "R5");
        set_cfg(0, 12'h123, 0, 1, 0, 8'h00); step();
        acc(1, 0, 12'h123, 8'h00); step(); chk(0, 2'b01, "R5");
        acc(0, 1, 12'h123, 8'h00); step(); chk(1, 2'b10, "R5");
        do_resume();
        set_cfg(0, 12'h123, 1, 1, 0, 8'h00); step();
        acc(1, 0, 12'h123, 8'h00); step(); chk(1, 2'b10, "R5");
        do_resume();
        acc(0, 1, 12'h123, 8'h00); step(); chk(1, 2'b10, "R5");
        do_resume();

        cur_req = "R3";
        brk_op = 1; step(); chk(0, 2'b10, "R3");

        cur_req = "R6";
        set_cfg(0, 12'h0FF, 1, 1, 1, 8'hA5); step();
        acc(0, 1, 12'h0FF, 8'hA4); step(); chk(0, 2'b10, "R6");
        acc(1, 0, 12'h0FF, 8'h25); step(); chk(0, 2'b10, "R6");
        acc(0, 1, 12'h0FF, 8'hA5); step(); chk(1, 2'b10, "R6");
        do_resume();
        set_cfg(0, 12'h0FF, 1, 1, 0, 8'hA5); step();
        acc(1, 0, 12'h0FF, 8'h00); step(); chk(1, 2'b10, "R6");
        do_resume();

        cur_req = "R11";
        set_cfg(1, 12'h200, 1, 0, 0, 8'h00);
        acc(1, 0, 12'h0FF, 8'h00); step(); chk(1, 2'b10, "R11");
        do_resume();
        acc(1, 0, 12'h0FF, 8'h00); step(); chk(0, 2'b10, "R11");
        set_cfg(0, 12'h200, 0, 0, 0, 8'h00);
        brk_op = 1; step(); chk(1, 2'b01, "R11");
        do_resume();
        acc(1, 0, 12'h200, 8'h00); step(); chk(0, 2'b01, "R11");

        repeat (3) step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule